// File: doc/BRIEF.md
# Guarded Byte-Store Write/Read Controller

This block sits between a CPU register bus and a small byte-wide nonvolatile store. Software sees three registers: an address register, a data register and a control register. The control register holds a read strobe, a write strobe that also serves as the busy flag, and an arming bit. A write reaches the store only through a two-step unlock. One control write sets the arming bit. A later control write sets the write strobe, and it must land while the arming bit is still alive. The arming bit expires by itself after a short window. A write is also refused while an external flash self-programming engine reports activity.

A started write holds the busy flag for a parameterised number of cycles and then commits to the store. The address and data are the values captured when the write started. While the write runs, the address register is frozen and read requests are dropped. A read copies the addressed byte into the data register at once. Both kinds of access hold a CPU stall output for a fixed number of cycles. An optional one-cycle completion pulse marks the end of each write.

Top module: `nvbyte_guard_ctl`

## Requirements
- R1: A control write that sets the write strobe (bit 1) starts a write only if the arming bit (bit 2) was already set before that write. Otherwise the busy flag stays 0 and the store is unchanged.
- R2: The arming bit reads 1 for exactly ARM_WINDOW (default 4) cycles after the edge that set it, and then clears by itself. A write strobe that lands on any of the ARM_WINDOW edges after the setting edge starts a write. A strobe that lands later is ignored.
- R3: The arming bit is set only by a control write that has bit 2 = 1 and bit 1 = 0. A control write with both bits set while unarmed sets neither bit. Any write-strobe attempt clears the arming bit.
- R4: The busy flag (control bit 1) reads 1 for exactly WRITE_CYCLES cycles after a start. The store then holds, at the address latched at the start, the data latched at the start.
- R5: No write starts while flash_busy is 1 on the strobe edge. The store keeps its old contents and the arming bit is consumed.
- R6: A write start holds cpu_stall high for exactly 2 cycles.
- R7: A control write with bit 0 = 1, made while not busy, loads the data register from the store at the current address on that edge. The read strobe (control bit 0) reads 1 for one cycle, and cpu_stall is high for exactly 4 cycles.
- R8: While busy, writes to the address register, read strobes and arming requests are ignored.
- R9: When HAS_DONE = 1, wr_done is high for exactly one cycle: the first cycle in which the busy flag reads 0 after a write.
- R10: Synchronous active-high reset clears the control bits, the address and data registers, the store, the counters, cpu_stall and wr_done.
- R11: Register select codes on bus_sel are 0 = address, 1 = data, 2 = control, 3 = reads zero. bus_rdata shows the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write enable |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Selected register contents |
| flash_busy | input | 1 | Flash self-programming active; blocks write starts |
| cpu_stall | output | 1 | CPU halt request |
| wr_done | output | 1 | One-cycle write-completion pulse |

## Verification
The bench writes a distinct computed byte to every address, then reads each one back. This separates a correct address latch from aliasing, and a correct commit from a lost write. The gap between arming and strobing is swept from zero to six idle cycles. The boundary between an accepted and an expired unlock must fall exactly after the fourth edge, and the rejected cases are checked through read-back of the unchanged store. Strobes without arming, combined arm-and-strobe writes, strobes under flash activity, and address and read requests made mid-write each tell a guard that blocks from one that leaks.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } nvg_sel_e;

   localparam int CTL_RD  = 0;
   localparam int CTL_WR  = 1;
   localparam int CTL_ARM = 2;
endpackage

// File: rtl/nvg_unlock.sv
module nvg_unlock #(
   parameter int WINDOW = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic set_req,
   input  logic clr_req,
   output logic armed
);
   localparam int CW = $clog2(WINDOW + 1);
   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed  <= 1'b0;
         left_q <= '0;
      end else if (clr_req) begin
         armed  <= 1'b0;
         left_q <= '0;
      end else if (set_req) begin
         armed  <= 1'b1;
         left_q <= CW'(WINDOW);
      end else if (armed) begin
         if (left_q == CW'(1)) begin
            armed  <= 1'b0;
            left_q <= '0;
         end else begin
            left_q <= left_q - CW'(1);
         end
      end
   end
endmodule

// File: rtl/nvg_wr_seq.sv
module nvg_wr_seq #(
   parameter int AW       = 4,
   parameter int DW       = 8,
   parameter int CYCLES   = 6,
   parameter bit HAS_DONE = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   output logic          busy,
   output logic          commit,
   output logic [AW-1:0] commit_addr,
   output logic [DW-1:0] commit_data,
   output logic          done
);
   localparam int CW = $clog2(CYCLES + 1);
   logic [CW-1:0] left_q;

   assign commit = busy && (left_q == CW'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy        <= 1'b0;
         left_q      <= '0;
         commit_addr <= '0;
         commit_data <= '0;
      end else if (start && !busy) begin
         busy        <= 1'b1;
         left_q      <= CW'(CYCLES);
         commit_addr <= addr_in;
         commit_data <= data_in;
      end else if (busy) begin
         left_q <= left_q - CW'(1);
         if (commit) busy <= 1'b0;
      end
   end

   generate
      if (HAS_DONE) begin : g_done
         logic done_q;
         always_ff @(posedge clk) begin
            if (rst) done_q <= 1'b0;
            else     done_q <= commit;
         end
         assign done = done_q;
      end else begin : g_no_done
         assign done = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/nvg_stall.sv
module nvg_stall #(
   parameter int SHORT = 2,
   parameter int LONG  = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic load_short,
   input  logic load_long,
   output logic stall
);
   localparam int MAXC = (SHORT > LONG) ? SHORT : LONG;
   localparam int CW   = $clog2(MAXC + 1);
   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst)             left_q <= '0;
      else if (load_short) left_q <= CW'(SHORT);
      else if (load_long)  left_q <= CW'(LONG);
      else if (left_q != '0) left_q <= left_q - CW'(1);
   end

   assign stall = (left_q != '0);
endmodule

// File: rtl/nvg_array.sv
module nvg_array #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] cell_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
      end else if (we) begin
         cell_q[waddr] <= wdata;
      end
   end

   assign rdata = cell_q[raddr];
endmodule

// File: rtl/nvbyte_guard_ctl.sv
module nvbyte_guard_ctl #(
   parameter int ADDR_W       = 4,
   parameter int DATA_W       = 8,
   parameter int WRITE_CYCLES = 6,
   parameter int ARM_WINDOW   = 4,
   parameter int WR_STALL     = 2,
   parameter int RD_STALL     = 4,
   parameter bit HAS_DONE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_we,
   input  logic [1:0]        bus_sel,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              flash_busy,
   output logic              cpu_stall,
   output logic              wr_done
);
   import nvg_pkg::*;

   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_aw
         $error("ADDR_W must be between 1 and DATA_W");
      end
      if (DATA_W < 3) begin : g_bad_dw
         $error("DATA_W must hold the three control bits");
      end
      if (WRITE_CYCLES < 1 || ARM_WINDOW < 1) begin : g_bad_cnt
         $error("WRITE_CYCLES and ARM_WINDOW must be positive");
      end
      if (WR_STALL < 1 || RD_STALL < 1) begin : g_bad_stall
         $error("stall lengths must be positive");
      end
   endgenerate

   logic              armed, busy, commit, rd_flag;
   logic [ADDR_W-1:0] addr_q, c_addr;
   logic [DATA_W-1:0] data_q, c_data, arr_rdata;
   logic              ctrl_wr, want_wr, want_arm, want_rd;
   logic              wr_start, arm_set, rd_go;

   assign ctrl_wr  = bus_we && (nvg_sel_e'(bus_sel) == SEL_CTRL);
   assign want_wr  = ctrl_wr && bus_wdata[CTL_WR];
   assign want_arm = ctrl_wr && bus_wdata[CTL_ARM] && !bus_wdata[CTL_WR];
   assign want_rd  = ctrl_wr && bus_wdata[CTL_RD];
   assign wr_start = want_wr && armed && !busy && !flash_busy;
   assign arm_set  = want_arm && !busy;
   assign rd_go    = want_rd && !busy && !wr_start;

   nvg_unlock #(.WINDOW(ARM_WINDOW)) u_unlock (
      .clk(clk), .rst(rst), .set_req(arm_set), .clr_req(want_wr), .armed(armed)
   );

   nvg_wr_seq #(.AW(ADDR_W), .DW(DATA_W), .CYCLES(WRITE_CYCLES), .HAS_DONE(HAS_DONE)) u_seq (
      .clk(clk), .rst(rst), .start(wr_start), .addr_in(addr_q), .data_in(data_q),
      .busy(busy), .commit(commit), .commit_addr(c_addr), .commit_data(c_data),
      .done(wr_done)
   );

   nvg_stall #(.SHORT(WR_STALL), .LONG(RD_STALL)) u_stall (
      .clk(clk), .rst(rst), .load_short(wr_start), .load_long(rd_go), .stall(cpu_stall)
   );

   nvg_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
      .clk(clk), .rst(rst), .we(commit), .waddr(c_addr), .wdata(c_data),
      .raddr(addr_q), .rdata(arr_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         data_q  <= '0;
         rd_flag <= 1'b0;
      end else begin
         rd_flag <= rd_go;
         if (bus_we && nvg_sel_e'(bus_sel) == SEL_ADDR && !busy)
            addr_q <= bus_wdata[ADDR_W-1:0];
         if (rd_go)
            data_q <= arr_rdata;
         else if (bus_we && nvg_sel_e'(bus_sel) == SEL_DATA)
            data_q <= bus_wdata;
      end
   end

   logic [DATA_W-1:0] addr_ext, ctrl_ext;
   always_comb begin
      addr_ext = '0;
      addr_ext[ADDR_W-1:0] = addr_q;
      ctrl_ext = '0;
      ctrl_ext[CTL_RD]  = rd_flag;
      ctrl_ext[CTL_WR]  = busy;
      ctrl_ext[CTL_ARM] = armed;
      case (nvg_sel_e'(bus_sel))
         SEL_ADDR: bus_rdata = addr_ext;
         SEL_DATA: bus_rdata = data_q;
         SEL_CTRL: bus_rdata = ctrl_ext;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/nvbyte_guard_ctl_chk.sv
module nvbyte_guard_ctl_chk #(
   parameter int ADDR_W     = 4,
   parameter int ARM_WINDOW = 4,
   parameter bit HAS_DONE   = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              armed,
   input logic              busy,
   input logic              rd_flag,
   input logic              flash_busy,
   input logic              cpu_stall,
   input logic              wr_done,
   input logic [ADDR_W-1:0] addr_q
);
   localparam int RW = $clog2(ARM_WINDOW + 2);
   logic [RW-1:0] arm_run;

   always_ff @(posedge clk) begin
      if (rst)        arm_run <= '0;
      else if (armed) arm_run <= (arm_run == {RW{1'b1}}) ? arm_run : arm_run + RW'(1);
      else            arm_run <= '0;
   end

   a_r1_start_needs_arm: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(armed));

   a_r2_arm_window: assert property (@(posedge clk) disable iff (rst)
      armed |-> (arm_run < RW'(ARM_WINDOW)));

   a_r5_no_start_flash: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> !$past(flash_busy));

   a_r6_write_stall: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> cpu_stall);

   a_r7_read_stall: assert property (@(posedge clk) disable iff (rst)
      rd_flag |-> (cpu_stall && !busy));

   a_r8_addr_locked: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(addr_q));

   a_r9_done_on_fall: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> (wr_done || !HAS_DONE));

   a_r9_done_only_fall: assert property (@(posedge clk) disable iff (rst)
      wr_done |-> $fell(busy));
endmodule

bind nvbyte_guard_ctl nvbyte_guard_ctl_chk #(
   .ADDR_W(ADDR_W), .ARM_WINDOW(ARM_WINDOW), .HAS_DONE(HAS_DONE)
) u_chk (
   .clk(clk), .rst(rst), .armed(armed), .busy(busy), .rd_flag(rd_flag),
   .flash_busy(flash_busy), .cpu_stall(cpu_stall), .wr_done(wr_done), .addr_q(addr_q)
);

// File: tb/nvbyte_guard_ctl_bench.sv
`timescale 1ns/1ps
module nvbyte_guard_ctl_bench;
   localparam int AW = 3;
   localparam int DW = 8;
   localparam int WCYC = 5;
   localparam int WIN = 4;
   localparam int DEPTH = 1 << AW;
   localparam logic [1:0] S_ADDR = 2'd0, S_DATA = 2'd1, S_CTRL = 2'd2, S_NONE = 2'd3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bus_we = 1'b0;
   logic [1:0]    bus_sel = S_CTRL;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          flash_busy = 1'b0;
   logic          cpu_stall, wr_done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic [DW-1:0] exp_mem [DEPTH];

   always #5 clk = ~clk;

   nvbyte_guard_ctl #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYCLES(WCYC),
                      .ARM_WINDOW(WIN), .WR_STALL(2), .RD_STALL(4), .HAS_DONE(1'b1))
   u_nvbyte_guard_ctl (
      .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .flash_busy(flash_busy), .cpu_stall(cpu_stall), .wr_done(wr_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a falling edge; the register write lands on the next rising edge
   task automatic poke(input logic [1:0] sel, input logic [DW-1:0] val);
      bus_we = 1'b1; bus_sel = sel; bus_wdata = val;
      @(negedge clk);
      bus_we = 1'b0; bus_sel = S_CTRL;
   endtask

   task automatic peek(input logic [1:0] sel, output int v);
      bus_sel = sel; #1; v = int'(bus_rdata); bus_sel = S_CTRL;
   endtask

   // counts busy, stall and done cycles after a strobe
   task automatic observe(output int nb, output int ns, output int nd, output int dat);
      int c;
      nb = 0; ns = 0; nd = 0; dat = -1;
      for (int i = 0; i < 16; i++) begin
         peek(S_CTRL, c);
         if (c[1]) nb++;
         if (cpu_stall) ns++;
         if (wr_done) begin nd++; dat = i; end
         @(negedge clk);
      end
   endtask

   task automatic do_read(input int a, input string req, input logic [DW-1:0] exp);
      int v, c, ns;
      poke(S_ADDR, DW'(a));
      poke(S_CTRL, 8'h01);
      peek(S_CTRL, c);
      chk({req, " R7 read strobe high"}, c & 1, 1);
      ns = 0;
      for (int i = 0; i < 8; i++) begin
         if (cpu_stall) ns++;
         @(negedge clk);
         if (i == 0) begin peek(S_CTRL, c); chk("R7 read strobe self-clears", c & 1, 0); end
      end
      chk("R7 read stall length", ns, 4);
      peek(S_DATA, v);
      chk({req, " read data"}, v, int'(exp));
   endtask

   initial begin
      int v, nb, ns, nd, dat;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R10 reset state
      peek(S_CTRL, v); chk("R10 control after reset", v, 0);
      peek(S_ADDR, v); chk("R10 address after reset", v, 0);
      peek(S_DATA, v); chk("R10 data after reset", v, 0);
      peek(S_NONE, v); chk("R11 unused select reads zero", v, 0);
      chk("R10 stall after reset", int'(cpu_stall), 0);
      chk("R10 done after reset", int'(wr_done), 0);
      for (int a = 0; a < DEPTH; a++) exp_mem[a] = '0;
      do_read(5, "R10 store cleared", 8'h00);

      // R4 R6 R9 sweep every address
      for (int a = 0; a < DEPTH; a++) begin
         logic [DW-1:0] d;
         d = DW'((a * 37 + 5) % 256);
         poke(S_ADDR, DW'(a));
         peek(S_ADDR, v); chk("R11 address readback", v, a);
         poke(S_DATA, d);
         poke(S_CTRL, 8'h04);
         peek(S_CTRL, v); chk("R3 arm bit set", (v >> 2) & 1, 1);
         poke(S_CTRL, 8'h02);
         observe(nb, ns, nd, dat);
         chk("R4 busy length", nb, WCYC);
         chk("R6 write stall length", ns, 2);
         chk("R9 done count", nd, 1);
         chk("R9 done position", dat, WCYC);
         exp_mem[a] = d;
      end
      for (int a = 0; a < DEPTH; a++) do_read(a, "R4 stored byte", exp_mem[a]);

      // R2 window sweep
      for (int g = 0; g <= 6; g++) begin
         logic [DW-1:0] d;
         d = DW'(8'hA0 + g);
         poke(S_ADDR, DW'(g));
         poke(S_DATA, d);
         poke(S_CTRL, 8'h04);
         repeat (g) @(negedge clk);
         poke(S_CTRL, 8'h02);
         observe(nb, ns, nd, dat);
         chk($sformatf("R2 gap %0d busy", g), nb, (g + 1 <= WIN) ? WCYC : 0);
         if (g + 1 <= WIN) exp_mem[g] = d;
         do_read(g, "R2 store after window", exp_mem[g]);
      end

      // R2 arm self-clear timing
      poke(S_CTRL, 8'h04);
      repeat (3) @(negedge clk);
      peek(S_CTRL, v); chk("R2 arm alive at cycle 4", (v >> 2) & 1, 1);
      @(negedge clk);
      peek(S_CTRL, v); chk("R2 arm cleared after window", (v >> 2) & 1, 0);

      // R1 strobe without arm; R3 combined write
      poke(S_ADDR, 8'd1); poke(S_DATA, 8'h11);
      poke(S_CTRL, 8'h02);
      peek(S_CTRL, v); chk("R1 unarmed strobe no busy", v, 0);
      poke(S_CTRL, 8'h06);
      peek(S_CTRL, v); chk("R3 combined write sets nothing", v, 0);
      repeat (WCYC + 1) @(negedge clk);
      do_read(1, "R1 store unchanged", exp_mem[1]);

      // R5 flash busy blocks
      poke(S_ADDR, 8'd3); poke(S_DATA, 8'h33);
      poke(S_CTRL, 8'h04);
      flash_busy = 1'b1;
      poke(S_CTRL, 8'h02);
      flash_busy = 1'b0;
      peek(S_CTRL, v); chk("R5 no busy under flash activity", v, 0);
      repeat (WCYC + 1) @(negedge clk);
      do_read(3, "R5 store unchanged", exp_mem[3]);

      // R8 requests during a write
      poke(S_ADDR, 8'd2); poke(S_DATA, 8'h5C);
      poke(S_CTRL, 8'h04);
      poke(S_CTRL, 8'h02);
      poke(S_ADDR, 8'd6);
      peek(S_ADDR, v); chk("R8 address locked while busy", v, 2);
      poke(S_CTRL, 8'h01);
      peek(S_CTRL, v); chk("R8 read ignored while busy", v, 2);
      chk("R8 no read stall while busy", int'(cpu_stall), 0);
      peek(S_DATA, v); chk("R8 data register untouched", v, 8'h5C);
      poke(S_CTRL, 8'h04);
      peek(S_CTRL, v); chk("R8 arm ignored while busy", (v >> 2) & 1, 0);
      repeat (WCYC + 2) @(negedge clk);
      exp_mem[2] = 8'h5C;
      do_read(2, "R8 write completed", exp_mem[2]);
      do_read(6, "R8 other address intact", exp_mem[6]);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule